// File: doc/BRIEF.md
# Manchester Line Codec with Violation Monitor

This block sits between a serial bit source and a radio modulator/demodulator. On transmit it turns each NRZ data bit into two half-bit line symbols: a 0 goes out as low then high, and a 1 goes out as high then low. Each half lasts `HALF_LEN` clock cycles, so the line runs at twice the bit rate. A single-cycle strobe loads each bit.

On receive it takes a line signal sampled `OSR` times per half-bit, with one sample per clock. It finds the mid-bit transitions and keeps its sampling phase locked to them. It samples the middle of each half and rebuilds the NRZ bits. Each bit comes out with a one-cycle valid strobe, together with a recovered bit clock that rises on that same cycle.

A half-bit pair with no mid-bit transition is a coding error. Coding errors are counted, and a run of good bits clears the count. When the count reaches a programmable threshold, a sticky error flag is raised. That flag stays set until a clear input is pulsed.

Top module: `manchester_codec`

## Requirements
- R1: Once `tx_bit_en` has been sampled high with `tx_nrz`=b, `tx_line` equals b for the next `HALF_LEN` cycles and then ~b for `HALF_LEN` cycles. So 0 is sent low-then-high and 1 is sent high-then-low.
- R2: Strobes spaced exactly 2·`HALF_LEN` cycles apart give an unbroken symbol stream. With no further strobe, `tx_line` holds the second-half level of the last bit.
- R3: After reset the receiver is unlocked. It takes the first line transition as a mid-bit transition, and the level just before that transition as the first half of that bit. A stream that starts from a low line with a 0 bit is therefore decoded from its first bit.
- R4: Once locked, a transition is accepted as mid-bit only within `OSR`/2 samples of the expected mid-bit point, and each accepted transition re-aligns the phase. Transitions at bit boundaries are ignored. The decoded bits equal the transmitted bits, in order, for any bit pattern.
- R5: `rx_valid` is high for exactly one cycle per decoded bit, with `rx_data` as the bit. `rx_bit_clk` rises in that same cycle and falls `OSR` cycles later.
- R6: A half-bit pair whose two halves are equal (00 or 11) produces no `rx_valid` and counts as one violation.
- R7: `viol_flag` rises when the violation count reaches `viol_thresh`. A threshold of 0 acts as 1. The count saturates.
- R8: `GOOD_CLR` consecutive good bits reset the violation count to zero.
- R9: Once set, `viol_flag` stays set until `viol_clr` is sampled high. A clear with no violation in the same cycle drops the flag on the next cycle.
- R10: A violation that reaches the threshold in the same cycle that `viol_clr` is high leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one receive sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_nrz | input | 1 | Bit to transmit, taken when `tx_bit_en` is high |
| tx_bit_en | input | 1 | One-cycle strobe that starts a new bit |
| tx_line | output | 1 | Encoded line symbols |
| rx_in | input | 1 | Oversampled received line |
| viol_thresh | input | THR_W | Violation count that raises the flag |
| viol_clr | input | 1 | Clears the sticky violation flag |
| rx_data | output | 1 | Decoded bit |
| rx_valid | output | 1 | One-cycle strobe per decoded bit |
| rx_bit_clk | output | 1 | Recovered bit clock |
| viol_flag | output | 1 | Sticky coding-violation flag |

## Verification
The clear input and a threshold-reaching violation can fall in the same cycle, and the set must win. The bench provokes this by locking the receiver on a known bit and then sending symbol pairs back to back. This makes the cycle in which a bad pair is judged fixed relative to the start of the pair. The bench then pulses `viol_clr` in exactly that cycle and expects the flag to stay high. As a control, it pulses the clear one cycle later and expects the flag to drop.

// File: rtl/mcodec_pkg.sv
package mcodec_pkg;
    // Verdict on one received half-bit pair, one cycle wide
    typedef struct packed {
        logic good;
        logic bad;
    } pair_res_t;
endpackage

// File: rtl/mcodec_tx.sv
module mcodec_tx #(
    parameter int HALF_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_nrz,
    input  logic tx_bit_en,
    output logic tx_line
);
    localparam int CNT_W = $clog2(2 * HALF_LEN);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(HALF_LEN - 1);
    localparam logic [CNT_W-1:0] END_LAST = CNT_W'(2 * HALF_LEN - 1);

    typedef struct packed {
        logic             line;
        logic             bit_v;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == MID_LAST) st_d.line = ~st_q.bit_v;
            if (st_q.cnt == END_LAST) st_d.busy = 1'b0;
        end
        if (tx_bit_en) begin
            st_d.line  = tx_nrz;
            st_d.bit_v = tx_nrz;
            st_d.cnt   = '0;
            st_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_line = st_q.line;

    // R1: the first half of every bit carries the bit value itself
    assert_first_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_en |=> (tx_line == $past(tx_nrz)));
endmodule

// File: rtl/mcodec_rx_align.sv
module mcodec_rx_align
    import mcodec_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_in,
    output logic      bit_val,
    output logic      bit_stb,
    output logic      bit_clk,
    output pair_res_t res
);
    localparam int PH_W = $clog2(2 * OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * OSR - 1);
    localparam logic [PH_W-1:0] SAMP_2ND = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0] SAMP_1ST = PH_W'(OSR + OSR / 2 - 1);
    localparam logic [PH_W-1:0] WIN_LO = PH_W'(2 * OSR - OSR / 2);
    localparam logic [PH_W-1:0] WIN_HI = PH_W'(OSR / 2 - 1);

    typedef struct packed {
        logic            s;
        logic            p;
        logic            locked;
        logic [PH_W-1:0] ph;
        logic            h1;
        logic            have_h1;
        logic            clk_o;
        logic            stb;
        logic            data;
        pair_res_t       res;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   edge_seen, in_win;

    always_comb begin
        edge_seen = st_q.s != st_q.p;
        in_win    = (st_q.ph >= WIN_LO) || (st_q.ph < WIN_HI);
        st_d      = st_q;
        st_d.s    = line_in;
        st_d.p    = st_q.s;
        st_d.stb  = 1'b0;
        st_d.res  = '0;
        st_d.ph   = (st_q.ph == PH_LAST) ? '0 : st_q.ph + 1'b1;
        if (edge_seen && (!st_q.locked || in_win)) begin
            st_d.ph = '0;
            if (!st_q.locked) begin
                st_d.locked  = 1'b1;
                st_d.h1      = st_q.p;
                st_d.have_h1 = 1'b1;
            end
        end
        if (st_q.locked && st_q.ph == SAMP_1ST) begin
            st_d.h1      = st_q.s;
            st_d.have_h1 = 1'b1;
            st_d.clk_o   = 1'b0;
        end
        if (st_q.locked && st_q.ph == SAMP_2ND && st_q.have_h1) begin
            st_d.have_h1 = 1'b0;
            if (st_q.h1 != st_q.s) begin
                st_d.stb      = 1'b1;
                st_d.data     = st_q.h1;
                st_d.clk_o    = 1'b1;
                st_d.res.good = 1'b1;
            end else begin
                st_d.res.bad  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_val = st_q.data;
    assign bit_stb = st_q.stb;
    assign bit_clk = st_q.clk_o;
    assign res     = st_q.res;

    // R5: each decoded bit lines up with a rising recovered clock
    assert_valid_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (bit_clk && !$past(bit_clk)));
    // R6: a pair is judged good or bad, never both
    assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res.good, res.bad}));
    // R6: a bad pair never yields a decoded bit
    assert_bad_no_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res.bad |-> !bit_stb);
endmodule

// File: rtl/mcodec_viol.sv
module mcodec_viol
    import mcodec_pkg::*;
#(
    parameter int THR_W    = 4,
    parameter int GOOD_CLR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pair_res_t        res,
    input  logic [THR_W-1:0] thresh,
    input  logic             clr,
    output logic             flag
);
    localparam int RUN_W = $clog2(GOOD_CLR + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_CLR - 1);

    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic [RUN_W-1:0] run;
        logic             flag;
    } vi_st_t;

    vi_st_t           st_d, st_q;
    logic [THR_W-1:0] eff_thr;

    always_comb begin
        eff_thr = (thresh == '0) ? THR_W'(1) : thresh;
        st_d    = st_q;
        if (clr) st_d.flag = 1'b0;
        if (res.bad) begin
            st_d.run = '0;
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt >= eff_thr) st_d.flag = 1'b1;
        end else if (res.good) begin
            if (st_q.run == RUN_LAST) begin
                st_d.run = '0;
                st_d.cnt = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R7: the flag only comes up following a bad pair
    assert_rise_on_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(res.bad));
    // R9: without a clear the flag holds
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R9: a clear with no concurrent violation drops the flag
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !res.bad) |=> !flag);
endmodule

// File: rtl/manchester_codec.sv
module manchester_codec
    import mcodec_pkg::*;
#(
    parameter int HALF_LEN = 8,
    parameter int OSR      = 8,
    parameter int THR_W    = 4,
    parameter int GOOD_CLR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_nrz,
    input  logic             tx_bit_en,
    output logic             tx_line,
    input  logic             rx_in,
    input  logic [THR_W-1:0] viol_thresh,
    input  logic             viol_clr,
    output logic             rx_data,
    output logic             rx_valid,
    output logic             rx_bit_clk,
    output logic             viol_flag
);
    pair_res_t pair_res;

    mcodec_tx #(.HALF_LEN(HALF_LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_nrz   (tx_nrz),
        .tx_bit_en(tx_bit_en),
        .tx_line  (tx_line)
    );

    mcodec_rx_align #(.OSR(OSR)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(rx_in),
        .bit_val(rx_data),
        .bit_stb(rx_valid),
        .bit_clk(rx_bit_clk),
        .res    (pair_res)
    );

    mcodec_viol #(.THR_W(THR_W), .GOOD_CLR(GOOD_CLR)) u_viol (
        .clk   (clk),
        .rst_n (rst_n),
        .res   (pair_res),
        .thresh(viol_thresh),
        .clr   (viol_clr),
        .flag  (viol_flag)
    );
endmodule

// File: tb/manchester_codec_test.sv
module manchester_codec_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_nrz = 1'b0, tx_bit_en = 1'b0;
    logic       loop_sel = 1'b0, rx_drv = 1'b0;
    logic [3:0] thr = 4'd1;
    logic       clr = 1'b0;
    logic       tx_line, rx_data, rx_valid, rx_bit_clk, viol_flag;
    logic       rx_in;
    int         checks = 0, errors = 0, ncap = 0;
    logic [63:0] cap;
    logic       clk_prev = 1'b0;

    assign rx_in = loop_sel ? tx_line : rx_drv;

    always #2 clk = ~clk;

    manchester_codec uut (
        .clk(clk), .rst_n(rst_n), .tx_nrz(tx_nrz), .tx_bit_en(tx_bit_en),
        .tx_line(tx_line), .rx_in(rx_in), .viol_thresh(thr), .viol_clr(clr),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_bit_clk(rx_bit_clk),
        .viol_flag(viol_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // capture decoded bits; R5 alignment of strobe and recovered clock
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            chk(rx_bit_clk && !clk_prev, "R5 valid on clock rise", int'(rx_bit_clk), 1);
            if (ncap < 64) cap[ncap] = rx_data;
            ncap++;
        end
        clk_prev = rx_bit_clk;
    end

    task automatic do_reset();
        rst_n = 1'b0; tx_bit_en = 1'b0; clr = 1'b0; rx_drv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ncap = 0;
        @(negedge clk);
    endtask

    task automatic tx_send(input logic b);
        tx_nrz = b; tx_bit_en = 1'b1;
        @(negedge clk);
        tx_bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_line == b, "R1 first half", int'(tx_line), int'(b));
        repeat (8) @(negedge clk);
        chk(tx_line == ~b, "R1 second half", int'(tx_line), int'(~b));
        repeat (4) @(negedge clk);
    endtask

    // one half-bit pair on the receive line; clr pulsed at offset clr_at
    task automatic rx_pair(input logic a, input logic b, input int clr_at);
        for (int i = 0; i < 16; i++) begin
            rx_drv = (i < 8) ? a : b;
            clr = (i == clr_at);
            @(negedge clk);
        end
        clr = 1'b0;
    endtask

    initial begin
        do_reset();
        chk(tx_line == 1'b0 && rx_valid == 1'b0 && viol_flag == 1'b0 && rx_bit_clk == 1'b0,
            "R9 reset state", int'({tx_line, rx_valid, viol_flag, rx_bit_clk}), 0);

        // R4 R3 R1 R2: loopback sweep over all 6-bit patterns behind a leading 0
        for (int p = 0; p < 64; p++) begin
            logic [6:0] exp_bits;
            exp_bits = {p[5:0], 1'b0};
            do_reset();
            loop_sel = 1'b1;
            for (int k = 0; k < 7; k++) tx_send(exp_bits[k]);
            repeat (20) @(negedge clk);
            chk(tx_line == ~exp_bits[6], "R2 line holds", int'(tx_line), int'(~exp_bits[6]));
            chk(ncap == 7, "R3 decoded count", ncap, 7);
            chk(cap[6:0] == exp_bits, "R4 decoded bits", int'(cap[6:0]), int'(exp_bits));
        end
        loop_sel = 1'b0;

        // R7 R6 R9: threshold versus violation count sweep
        for (int t = 0; t < 5; t++) begin
            for (int nv = 0; nv < 5; nv++) begin
                int eff;
                eff = (t == 0) ? 1 : t;
                do_reset();
                thr = 4'(t);
                rx_pair(1'b0, 1'b1, -1);
                for (int k = 0; k < nv; k++) begin
                    rx_pair(1'b1, 1'b1, -1);
                    rx_pair(1'b0, 1'b1, -1);
                end
                rx_pair(1'b1, 1'b0, -1);
                rx_pair(1'b0, 1'b1, -1);
                chk(viol_flag == (nv >= eff), "R7 threshold", int'(viol_flag), int'(nv >= eff));
                chk(ncap == 3 + nv, "R6 no bit on violation", ncap, 3 + nv);
                if (nv >= eff) begin
                    clr = 1'b1;
                    @(negedge clk);
                    clr = 1'b0;
                    @(negedge clk);
                    chk(viol_flag == 1'b0, "R9 clear", int'(viol_flag), 0);
                end
            end
        end

        // R8: good-bit run resets the count
        for (int n = 3; n < 6; n++) begin
            do_reset();
            thr = 4'd2;
            rx_pair(1'b0, 1'b1, -1);
            rx_pair(1'b1, 1'b1, -1);
            for (int k = 0; k < n; k++) rx_pair(1'b0, 1'b1, -1);
            rx_pair(1'b1, 1'b1, -1);
            rx_pair(1'b0, 1'b1, -1);
            chk(viol_flag == (n < 4), "R8 good run clears count", int'(viol_flag), int'(n < 4));
        end

        // R10: clear coincides with a threshold-reaching violation; set wins
        do_reset();
        thr = 4'd1;
        rx_pair(1'b0, 1'b1, -1);
        rx_pair(1'b1, 1'b1, -1);
        rx_pair(1'b0, 1'b1, -1);
        chk(viol_flag == 1'b1, "R7 flag set", int'(viol_flag), 1);
        rx_pair(1'b1, 1'b1, 14);
        chk(viol_flag == 1'b1, "R10 set beats clear", int'(viol_flag), 1);
        // control: clear one cycle after the violation verdict
        rx_pair(1'b0, 1'b1, -1);
        rx_pair(1'b1, 1'b1, 15);
        chk(viol_flag == 1'b0, "R10 control late clear", int'(viol_flag), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule